// File: doc/BRIEF.md
# Predicate and Condition Flag Unit

This block decides, for each instruction presented to it, whether that instruction is allowed to take effect. Every 32-bit instruction carries a 4-bit predicate in its top nibble, bits [31:28]. The block tests that predicate against four stored condition flags: negative, zero, carry and overflow. It drives an execute-enable in the same cycle. An instruction whose predicate fails keeps its pipeline slot for one cycle, but the block holds its enable low for that cycle.

The block also holds the four flags. It updates them from the ALU result, the carry and the overflow in two cases: when the instruction asks for a flag update through its set bit, and when the instruction belongs to the compare class, whose only effect is to change the flags. In either case the predicate of that same instruction must pass. New flags are registered, so the instruction in the next cycle tests against them. The decoder feeds the predicate nibble and the two class bits. The ALU feeds the result with its carry and overflow. The execute-enable gates writeback further down the pipeline.

Top module: `cond_flag_unit`

## Requirements
- R1: While reset is asserted, and in the first cycle after it is released, all four flags (N, Z, C, V) read 0.
- R2: When `instr_valid` is low, `exec_en` is low, whatever the predicate and the flags are.
- R3: With `instr_valid` high, `exec_en` follows the predicate code as follows: 0000 Z=1; 0001 Z=0; 0010 C=1; 0011 C=0; 0100 N=1; 0101 N=0; 0110 V=1; 0111 V=0.
- R4: With `instr_valid` high, `exec_en` follows the predicate code as follows: 1000 C=1 and Z=0; 1001 C=0 or Z=1; 1010 N==V; 1011 N!=V; 1100 Z=0 and N==V; 1101 Z=1 or N!=V.
- R5: Code 1110 always enables a valid instruction. Code 1111 never enables one.
- R6: When an enabled instruction has `set_flags` high, the flags after the next rising edge are: N = MSB of `alu_result`, Z = 1 exactly when `alu_result` is all zeroes, C = `alu_carry`, V = `alu_overflow`.
- R7: An enabled instruction with `is_compare` high updates the flags as in R6, even when `set_flags` is low.
- R8: An enabled instruction with both `set_flags` and `is_compare` low leaves all four flags unchanged.
- R9: An instruction whose predicate fails, or whose `instr_valid` is low, leaves all four flags unchanged, even when `set_flags` or `is_compare` is high.
- R10: `exec_en` depends on the flags as stored at the start of the cycle. A flag update becomes visible to the predicate test in the following cycle, not in the cycle that causes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| instr_valid | input | 1 | An instruction occupies this cycle |
| cond_code | input | 4 | Predicate nibble, instruction bits [31:28] |
| set_flags | input | 1 | Instruction requests a flag update |
| is_compare | input | 1 | Instruction is of the compare class |
| alu_result | input | DATA_W | ALU result of this instruction |
| alu_carry | input | 1 | Carry out of the ALU or shifter |
| alu_overflow | input | 1 | Signed overflow of the ALU |
| exec_en | output | 1 | Instruction may take effect this cycle |
| flag_n | output | 1 | Stored negative flag |
| flag_z | output | 1 | Stored zero flag |
| flag_c | output | 1 | Stored carry flag |
| flag_v | output | 1 | Stored overflow flag |

## Verification
The assertions assume that the instruction inputs are steady around each rising edge, and that `alu_result`, `alu_carry` and `alu_overflow` belong to the instruction shown in the same cycle. They place no constraint on which input combinations are legal. Any predicate code may be paired with any class bits, and with `instr_valid` either high or low. The stimulus changes inputs only on falling edges. It draws random codes, class bits and ALU values, biased towards all-zero and sign-set results so that every flag is seen in both states. A directed sweep applies all sixteen codes against chosen flag patterns.

// File: rtl/cond_flag_unit.sv
module cond_flag_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [3:0]        cond_code,
  input  logic              set_flags,
  input  logic              is_compare,
  input  logic [DATA_W-1:0] alu_result,
  input  logic              alu_carry,
  input  logic              alu_overflow,
  output logic              exec_en,
  output logic              flag_n,
  output logic              flag_z,
  output logic              flag_c,
  output logic              flag_v
);

  localparam int MSB = DATA_W - 1;

  logic [3:0] nzcv_q;
  logic [3:0] nzcv_d;
  logic       pass;
  logic       upd;

  assign {flag_n, flag_z, flag_c, flag_v} = nzcv_q;

  always_comb begin
    case (cond_code)
      4'h0:    pass = flag_z;
      4'h1:    pass = !flag_z;
      4'h2:    pass = flag_c;
      4'h3:    pass = !flag_c;
      4'h4:    pass = flag_n;
      4'h5:    pass = !flag_n;
      4'h6:    pass = flag_v;
      4'h7:    pass = !flag_v;
      4'h8:    pass = flag_c && !flag_z;
      4'h9:    pass = !flag_c || flag_z;
      4'hA:    pass = flag_n == flag_v;
      4'hB:    pass = flag_n != flag_v;
      4'hC:    pass = !flag_z && (flag_n == flag_v);
      4'hD:    pass = flag_z || (flag_n != flag_v);
      4'hE:    pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

  assign exec_en = instr_valid && pass;
  assign upd     = exec_en && (set_flags || is_compare);
  assign nzcv_d  = {alu_result[MSB], ~|alu_result, alu_carry, alu_overflow};

  always_ff @(posedge clk) begin
    if (!rst_n)   nzcv_q <= 4'b0000;
    else if (upd) nzcv_q <= nzcv_d;
  end

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> ({flag_n, flag_z, flag_c, flag_v} == 4'b0000)); // R1
  AST_IDLE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> !exec_en); // R2
  AST_ALWAYS_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && cond_code == 4'hE) |-> exec_en); // R5
  AST_NEVER_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == 4'hF) |-> !exec_en); // R5
  AST_UPDATE_N: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (set_flags || is_compare)) |=> (flag_n == $past(alu_result[MSB]))); // R6
  AST_UPDATE_ZCV: assert property (@(posedge clk) disable iff (!rst_n)
    (exec_en && (set_flags || is_compare)) |=>
      ({flag_z, flag_c, flag_v} == {$past(alu_result == '0), $past(alu_carry), $past(alu_overflow)})); // R7
  AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    !(exec_en && (set_flags || is_compare)) |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R8
  AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !exec_en |=> $stable({flag_n, flag_z, flag_c, flag_v})); // R9

endmodule

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              instr_valid = 1'b0;
  logic [3:0]        cond_code = 4'h0;
  logic              set_flags = 1'b0;
  logic              is_compare = 1'b0;
  logic [DATA_W-1:0] alu_result = '0;
  logic              alu_carry = 1'b0;
  logic              alu_overflow = 1'b0;
  logic              exec_en;
  logic              flag_n, flag_z, flag_c, flag_v;

  int checks = 0;
  int errors = 0;
  logic [3:0] model_f = 4'b0000;

  always #4 clk = ~clk;

  cond_flag_unit #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .cond_code(cond_code),
    .set_flags(set_flags), .is_compare(is_compare), .alu_result(alu_result),
    .alu_carry(alu_carry), .alu_overflow(alu_overflow), .exec_en(exec_en),
    .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v)
  );

  function automatic logic want_pass(input logic [3:0] cc, input logic [3:0] f);
    logic n, z, c, v;
    {n, z, c, v} = f;
    case (cc)
      4'h0: return z;
      4'h1: return !z;
      4'h2: return c;
      4'h3: return !c;
      4'h4: return n;
      4'h5: return !n;
      4'h6: return v;
      4'h7: return !v;
      4'h8: return c & !z;
      4'h9: return !c | z;
      4'hA: return n ~^ v;
      4'hB: return n ^ v;
      4'hC: return !z & (n ~^ v);
      4'hD: return z | (n ^ v);
      4'hE: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  function automatic string cond_tag(input logic [3:0] cc, input logic v);
    if (!v) return "R2";
    if (cc < 4'h8) return "R3";
    if (cc < 4'hE) return "R4";
    return "R5";
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [3:0] cc, input logic s, input logic cmp,
                      input logic [DATA_W-1:0] res, input logic c, input logic ov);
    logic pass;
    string ftag;
    @(negedge clk);
    instr_valid = v; cond_code = cc; set_flags = s; is_compare = cmp;
    alu_result = res; alu_carry = c; alu_overflow = ov;
    #1;
    pass = v && want_pass(cc, model_f);
    check(cond_tag(cc, v), {31'b0, exec_en}, {31'b0, pass}); // R10: tested against stored flags
    if (!pass) ftag = "R9";
    else if (s) ftag = "R6";
    else if (cmp) ftag = "R7";
    else ftag = "R8";
    if (pass && (s || cmp)) model_f = {res[DATA_W-1], res == '0, c, ov};
    @(posedge clk);
    #1;
    check(ftag, {28'b0, flag_n, flag_z, flag_c, flag_v}, {28'b0, model_f});
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1;
    check("R1", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
    check("R1", {28'b0, flag_n, flag_z, flag_c, flag_v}, 32'h0);

    // R5 / R10: set Z and C, then sweep all sixteen codes with no flag request
    step(1'b1, 4'hE, 1'b1, 1'b0, '0, 1'b1, 1'b0);
    for (int k = 0; k < 16; k++) step(1'b1, 4'(k), 1'b0, 1'b0, 32'h1234, 1'b0, 1'b1);
    // N and V set together
    step(1'b1, 4'hE, 1'b0, 1'b1, 32'h8000_0000, 1'b0, 1'b1);
    for (int k = 0; k < 16; k++) step(1'b1, 4'(k), 1'b0, 1'b0, 32'h0, 1'b1, 1'b0);
    // N set, V clear
    step(1'b1, 4'hE, 1'b1, 1'b0, 32'hF000_0001, 1'b0, 1'b0);
    for (int k = 0; k < 16; k++) step(1'b1, 4'(k), 1'b0, 1'b0, 32'h0, 1'b1, 1'b1);
    // R9: failing compare leaves flags; R2: invalid with code AL
    step(1'b1, 4'h0, 1'b1, 1'b1, 32'h0, 1'b1, 1'b1);
    step(1'b0, 4'hE, 1'b1, 1'b1, 32'h0, 1'b1, 1'b1);
    step(1'b1, 4'hF, 1'b1, 1'b1, 32'h0, 1'b1, 1'b1);
    // R10: back-to-back update then dependent test
    step(1'b1, 4'hE, 1'b0, 1'b1, 32'h0, 1'b0, 1'b0);
    step(1'b1, 4'h0, 1'b1, 1'b0, 32'h5, 1'b0, 1'b0);
    step(1'b1, 4'h0, 1'b0, 1'b0, 32'h5, 1'b0, 1'b0);

    for (int i = 0; i < 4000; i++) begin
      logic [DATA_W-1:0] r;
      int sel;
      sel = $urandom_range(0, 3);
      r = (sel == 0) ? '0 : (sel == 1) ? {1'b1, 31'($urandom)} : DATA_W'($urandom);
      step(($urandom_range(0, 7) != 0), 4'($urandom), 1'($urandom), 1'($urandom),
           r, 1'($urandom), 1'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule